// File: doc/BRIEF.md
# Bus parity generator and checker

This block sits beside the master and target logic of an agent on a 32-bit multiplexed address/data bus that carries a 4-bit command/byte-enable group with it. On every clock where this agent drives the bus word, it computes an even parity bit over the word and the command/byte-enable lines. It drives that bit one clock later, which is when the bus expects parity for that word.

On words this agent receives, it keeps the expected parity for one clock and compares it with the parity bit sampled from the bus. A data word is checked only on a transfer clock, which is a clock where both ready strobes are low. An address word is checked only on the first clock of a transaction.

A bad data word pulls the shared data-error line low two clocks after the transfer. The line is then driven high for one clock and released. A bad address, or a bad data word inside a broadcast transaction (command code 4'b0001), pulls the open-drain system-error line low instead. A sticky flag records any detected error until a local write-one-to-clear pulse clears it.

All control and status pins are plain levels. The block carries no data stream of its own, so it has no valid/ready handshake and no back-pressure.

Top module: `bus_parity_unit`

## Requirements
- R1: In the clock after an edge where `own_drive_i` is 1, `par_oe_o` is 1 and `par_o` equals the XOR of all bits of `word_i` and `lane_n_i` at that edge. The ones in word, lanes and parity bit then total an even number.
- R2: In the clock after an edge where `own_drive_i` is 0, `par_oe_o` is 0.
- R3: An address phase is an edge with `start_n_i` low where `start_n_i` was high at the previous edge. If this agent does not drive that address and `par_i` at the next edge mismatches, `serr_pull_o` is 1 for the clock after that next edge.
- R4: A received data phase is an edge with `init_rdy_n_i`=0, `tgt_rdy_n_i`=0, `rx_data_i`=1 and `own_drive_i`=0. If `par_i` at the next edge mismatches, then after that next edge `derr_oe_o`=1 and `derr_o`=0 for one clock.
- R5: After the last clock with `derr_o` low, the block drives `derr_o`=1 with `derr_oe_o`=1 for one clock and then sets `derr_oe_o`=0. Bad data phases on back-to-back edges keep `derr_o` low without a high clock in between.
- R6: An edge where either ready strobe is high is not checked, whatever the parity.
- R7: Clocks of a transaction after its first, with `start_n_i` still low, are not checked as addresses.
- R8: When the lane value at the address phase is 4'b0001, bad received data phases of that transaction raise `serr_pull_o` with the R4 timing, and `derr_oe_o` stays 0.
- R9: Words this agent drives (`own_drive_i`=1) are never checked.
- R10: `sticky_o` becomes 1 in the same clock as any error pin assertion. `clr_i`=1 at an edge clears it unless an error is set at that same edge, in which case the set wins.
- R11: While `rst_n` is low, `par_oe_o`, `derr_oe_o`, `serr_pull_o` and `sticky_o` are 0.
- R12: Received words with correct parity raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | WORD_W | Bus address/data word as sampled |
| lane_n_i | input | LANE_W | Command (address phase) or active-low byte enables (data phase) |
| start_n_i | input | 1 | Active-low transaction frame strobe |
| init_rdy_n_i | input | 1 | Active-low initiator ready |
| tgt_rdy_n_i | input | 1 | Active-low target ready |
| own_drive_i | input | 1 | This agent drives word and lanes at this edge |
| rx_data_i | input | 1 | This agent receives data phases of the current transaction |
| par_i | input | 1 | Parity bit sampled from the bus |
| clr_i | input | 1 | Write-one-to-clear for the sticky flag |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for `par_o` |
| derr_o | output | 1 | Data-error line value, low is active |
| derr_oe_o | output | 1 | Output enable for the data-error line |
| serr_pull_o | output | 1 | 1 pulls the open-drain system-error line low |
| sticky_o | output | 1 | Sticky error flag |

## Verification
The bench builds the block with WORD_W=32, LANE_W=4 and a broadcast code of 4'b0001. The 36 parity inputs do not fill a power of two, so the zero-padded upper leaves of the reduction tree are part of every comparison. With four lanes, the broadcast code can be matched exactly while other command codes on the same lanes are used as the negative case. The stimulus includes back-to-back bad data phases, wait states carrying wrong parity, and long frames. With these, the hold and release order of the data-error line and the single-address rule are observed at the pins.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  // One word awaiting its parity bit on the following edge.
  typedef struct packed {
    logic vld;   // a received word must be compared
    logic sys;   // mismatch reported on the system-error line
    logic expd;  // parity bit the word requires
  } chk_pend_t;

  localparam chk_pend_t PEND_IDLE = '{vld: 1'b0, sys: 1'b0, expd: 1'b0};

endpackage

// File: rtl/bpu_xor_tree.sv
module bpu_xor_tree #(
  parameter int N = 36
) (
  input  logic [N-1:0] bits_i,
  output logic         odd_o
);
  localparam int LG = (N > 1) ? $clog2(N) : 0;
  localparam int P  = 1 << LG;

  logic [P-1:0]   leaf;
  logic [2*P-1:1] node;

  // Heap-ordered balanced tree: node i combines nodes 2i and 2i+1.
  always_comb begin
    leaf = '0;
    leaf[N-1:0] = bits_i;
    node = '0;
    for (int i = 0; i < P; i++) node[P+i] = leaf[i];
    for (int i = P - 1; i >= 1; i--) node[i] = node[2*i] ^ node[2*i+1];
  end

  assign odd_o = node[1];

endmodule

// File: rtl/bpu_phase_qual.sv
module bpu_phase_qual #(
  parameter int              LANE_W      = 4,
  parameter logic [LANE_W-1:0] CMD_SPECIAL = LANE_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n_i,
  input  logic              init_rdy_n_i,
  input  logic              tgt_rdy_n_i,
  input  logic [LANE_W-1:0] lane_n_i,
  input  logic              own_drive_i,
  input  logic              rx_data_i,
  output logic              addr_chk_o,
  output logic              data_chk_o,
  output logic              sys_data_o
);
  logic start_prev_n;
  logic special_q;
  logic addr_ph;
  logic xfer_ph;

  assign addr_ph    = ~start_n_i & start_prev_n;
  assign xfer_ph    = ~init_rdy_n_i & ~tgt_rdy_n_i;
  assign addr_chk_o = addr_ph & ~own_drive_i;
  assign data_chk_o = xfer_ph & rx_data_i & ~own_drive_i;
  assign sys_data_o = data_chk_o & special_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prev_n <= 1'b1;
      special_q    <= 1'b0;
    end else begin
      start_prev_n <= start_n_i;
      if (addr_ph) special_q <= (lane_n_i == CMD_SPECIAL);
    end
  end

  AST_ADDR_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> !addr_ph); // R7

endmodule

// File: rtl/bpu_par_gen.sv
module bpu_par_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic odd_i,
  input  logic own_drive_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= odd_i;
      par_oe_o <= own_drive_i;
    end
  end

endmodule

// File: rtl/bpu_par_check.sv
module bpu_par_check
  import bpu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic odd_i,
  input  logic addr_chk_i,
  input  logic data_chk_i,
  input  logic sys_data_i,
  input  logic par_i,
  output logic data_err_o,
  output logic sys_err_o
);
  chk_pend_t pend_q;
  logic      miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_IDLE;
    end else begin
      pend_q.vld  <= addr_chk_i | data_chk_i;
      pend_q.sys  <= addr_chk_i | sys_data_i;
      pend_q.expd <= odd_i;
    end
  end

  assign miss       = pend_q.vld & (pend_q.expd ^ par_i);
  assign data_err_o = miss & ~pend_q.sys;
  assign sys_err_o  = miss & pend_q.sys;

  AST_ERR_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err_o || sys_err_o) |-> $past(addr_chk_i || data_chk_i)); // R6

endmodule

// File: rtl/bpu_err_report.sv
module bpu_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic data_err_i,
  input  logic sys_err_i,
  input  logic clr_i,
  output logic derr_o,
  output logic derr_oe_o,
  output logic serr_pull_o,
  output logic sticky_o
);
  logic low_q;
  logic high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q       <= 1'b0;
      high_q      <= 1'b0;
      serr_pull_o <= 1'b0;
      sticky_o    <= 1'b0;
    end else begin
      low_q       <= data_err_i;
      high_q      <= low_q & ~data_err_i;
      serr_pull_o <= sys_err_i;
      sticky_o    <= data_err_i | sys_err_i | (sticky_o & ~clr_i);
    end
  end

  assign derr_o    = ~low_q;
  assign derr_oe_o = low_q | high_q;

  AST_DERR_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!derr_oe_o && $past(derr_oe_o)) |-> $past(derr_o)); // R5
  AST_DERR_HELD_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (derr_oe_o && !derr_o) |=> derr_oe_o); // R5
  AST_STICKY_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_pull_o || (derr_oe_o && !derr_o)) |-> sticky_o); // R10

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int                WORD_W      = 32,
  parameter int                LANE_W      = 4,
  parameter logic [LANE_W-1:0] CMD_SPECIAL = LANE_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_n_i,
  input  logic              start_n_i,
  input  logic              init_rdy_n_i,
  input  logic              tgt_rdy_n_i,
  input  logic              own_drive_i,
  input  logic              rx_data_i,
  input  logic              par_i,
  input  logic              clr_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              derr_o,
  output logic              derr_oe_o,
  output logic              serr_pull_o,
  output logic              sticky_o
);
  localparam int TOTAL_W = WORD_W + LANE_W;

  logic word_odd;
  logic addr_chk;
  logic data_chk;
  logic sys_data;
  logic data_err;
  logic sys_err;

  bpu_xor_tree #(.N(TOTAL_W)) u_tree (
    .bits_i ({word_i, lane_n_i}),
    .odd_o  (word_odd)
  );

  bpu_phase_qual #(.LANE_W(LANE_W), .CMD_SPECIAL(CMD_SPECIAL)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n_i    (start_n_i),
    .init_rdy_n_i (init_rdy_n_i),
    .tgt_rdy_n_i  (tgt_rdy_n_i),
    .lane_n_i     (lane_n_i),
    .own_drive_i  (own_drive_i),
    .rx_data_i    (rx_data_i),
    .addr_chk_o   (addr_chk),
    .data_chk_o   (data_chk),
    .sys_data_o   (sys_data)
  );

  bpu_par_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .odd_i       (word_odd),
    .own_drive_i (own_drive_i),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o)
  );

  bpu_par_check u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .odd_i      (word_odd),
    .addr_chk_i (addr_chk),
    .data_chk_i (data_chk),
    .sys_data_i (sys_data),
    .par_i      (par_i),
    .data_err_o (data_err),
    .sys_err_o  (sys_err)
  );

  bpu_err_report u_report (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_err_i  (data_err),
    .sys_err_i   (sys_err),
    .clr_i       (clr_i),
    .derr_o      (derr_o),
    .derr_oe_o   (derr_oe_o),
    .serr_pull_o (serr_pull_o),
    .sticky_o    (sticky_o)
  );

  AST_SPECIAL_NO_DERR: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> !data_err); // R8

endmodule

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic [3:0]  lane_n_i = 4'hF;
  logic        start_n_i = 1'b1, init_rdy_n_i = 1'b1, tgt_rdy_n_i = 1'b1;
  logic        own_drive_i = 1'b0, rx_data_i = 1'b0, par_i = 1'b0, clr_i = 1'b0;
  logic        par_o, par_oe_o, derr_o, derr_oe_o, serr_pull_o, sticky_o;

  always #2 clk = ~clk;

  bus_parity_unit dut_i (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .lane_n_i(lane_n_i),
    .start_n_i(start_n_i), .init_rdy_n_i(init_rdy_n_i), .tgt_rdy_n_i(tgt_rdy_n_i),
    .own_drive_i(own_drive_i), .rx_data_i(rx_data_i), .par_i(par_i), .clr_i(clr_i),
    .par_o(par_o), .par_oe_o(par_oe_o), .derr_o(derr_o), .derr_oe_o(derr_oe_o),
    .serr_pull_o(serr_pull_o), .sticky_o(sticky_o)
  );

  typedef struct {
    int   edge_no;
    logic par_oe, par, derr_oe, derr, serr, sticky;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    edge_cnt = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // requirement model state
  logic m_prev_fr = 1'b1, m_spec = 1'b0, m_pv = 1'b0, m_ps = 1'b0;
  logic m_pe = 1'b0, m_pb = 1'b0, m_low = 1'b0, m_stk = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input string req, input string what, input logic got, input logic expv);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s edge %0d got %b expected %b", req, what, edge_cnt, got, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].edge_no == edge_cnt) begin
      exp_t  it;
      string tg;
      it = sb_q.pop_front();
      tg = tag_q.pop_front();
      chk({tg, "/R1"}, "par_oe_o", par_oe_o, it.par_oe);
      if (it.par_oe) chk({tg, "/R1"}, "par_o", par_o, it.par);
      chk({tg, "/R4"}, "derr_oe_o", derr_oe_o, it.derr_oe);
      if (it.derr_oe) chk({tg, "/R5"}, "derr_o", derr_o, it.derr);
      chk({tg, "/R3"}, "serr_pull_o", serr_pull_o, it.serr);
      chk({tg, "/R10"}, "sticky_o", sticky_o, it.sticky);
    end
  end

  // driver: sets inputs for the next edge and pushes what must follow it
  task automatic drv(input logic [31:0] w, input logic [3:0] ln, input logic fr,
                     input logic ir, input logic tr, input logic own, input logic rx,
                     input logic bad, input logic clr, input string tag);
    exp_t it;
    logic err, lo, sy, hi, addr, ca, cd;
    @(negedge clk);
    word_i = w; lane_n_i = ln; start_n_i = fr; init_rdy_n_i = ir; tgt_rdy_n_i = tr;
    own_drive_i = own; rx_data_i = rx; clr_i = clr;
    par_i = m_pe ^ m_pb;
    err = m_pv & m_pb;
    lo  = err & !m_ps;
    sy  = err & m_ps;
    hi  = m_low & !lo;
    m_stk = (m_stk & !clr) | err;
    it.edge_no = edge_cnt + 1;
    it.par_oe  = own;
    it.par     = ^{w, ln};
    it.derr_oe = lo | hi;
    it.derr    = !lo;
    it.serr    = sy;
    it.sticky  = m_stk;
    sb_q.push_back(it);
    tag_q.push_back(tag);
    addr = !fr & m_prev_fr;
    ca   = addr & !own;
    cd   = !ir & !tr & rx & !own;
    m_pv = ca | cd;
    m_ps = ca | (cd & m_spec);
    m_pe = ^{w, ln};
    m_pb = bad;
    if (addr) m_spec = (ln == 4'b0001);
    m_prev_fr = fr;
    m_low = lo;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drv(32'h0, 4'hF, 1, 1, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at edge %0d", edge_cnt);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    chk("R11", "par_oe_o", par_oe_o, 1'b0);
    chk("R11", "derr_oe_o", derr_oe_o, 1'b0);
    chk("R11", "serr_pull_o", serr_pull_o, 1'b0);
    chk("R11", "sticky_o", sticky_o, 1'b0);
    rst_n = 1'b1;
    idle(2, "R2");

    // R1: own write transaction, parity on each driven word; R2 after it
    drv(32'h1000_0040, 4'b0111, 0, 1, 1, 1, 0, 0, 0, "R1");
    drv(32'hDEAD_BEEF, 4'b0000, 0, 0, 0, 1, 0, 0, 0, "R1");
    drv(32'h0000_0001, 4'b0011, 1, 0, 0, 1, 0, 0, 0, "R1");
    idle(2, "R2");

    // R4, R6: received write, wait state with wrong parity, one bad transfer
    drv(32'h2000_0000, 4'b0111, 0, 1, 1, 0, 0, 0, 0, "R12");
    drv(32'h1234_5678, 4'b0000, 0, 0, 0, 0, 1, 0, 0, "R12");
    drv(32'hFFFF_0000, 4'b0000, 0, 0, 1, 0, 1, 1, 0, "R6");
    drv(32'hA5A5_A5A5, 4'b0000, 0, 0, 0, 0, 1, 1, 0, "R4");
    drv(32'h0F0F_0F0F, 4'b1100, 1, 0, 0, 0, 1, 0, 0, "R4");
    idle(4, "R5");

    // R3: received address with bad parity
    drv(32'h3000_0010, 4'b0110, 0, 1, 1, 0, 0, 1, 0, "R3");
    drv(32'h0000_00FF, 4'b0000, 1, 0, 0, 0, 1, 0, 0, "R3");
    idle(3, "R3");

    // R7: long frame, later clocks carry wrong parity but are not addresses
    drv(32'h4000_0000, 4'b0110, 0, 1, 1, 0, 0, 0, 0, "R7");
    drv(32'h1111_1111, 4'b0110, 0, 1, 1, 0, 0, 1, 0, "R7");
    drv(32'h2222_2222, 4'b0110, 0, 1, 1, 0, 0, 1, 0, "R7");
    drv(32'h3333_3333, 4'b0000, 1, 0, 0, 0, 1, 0, 0, "R7");
    idle(3, "R7");

    // R8: broadcast transaction (code 4'b0001) with bad data goes to system error
    drv(32'h0000_0000, 4'b0001, 0, 1, 1, 0, 0, 0, 0, "R8");
    drv(32'h0000_0002, 4'b0000, 1, 0, 0, 0, 1, 1, 0, "R8");
    idle(3, "R8");

    // R5: two back-to-back bad transfers keep the line low, then high, then released
    drv(32'h5000_0000, 4'b0111, 0, 1, 1, 0, 0, 0, 0, "R5");
    drv(32'h0101_0101, 4'b0000, 0, 0, 0, 0, 1, 1, 0, "R5");
    drv(32'h0202_0202, 4'b0000, 0, 0, 0, 0, 1, 1, 0, "R5");
    drv(32'h0303_0303, 4'b0000, 1, 0, 0, 0, 1, 0, 0, "R5");
    idle(4, "R5");

    // R9: words this agent drives with wrong bus parity are not checked
    drv(32'h6000_0000, 4'b0111, 0, 1, 1, 1, 0, 1, 0, "R9");
    drv(32'h7777_7777, 4'b0000, 1, 0, 0, 1, 1, 1, 0, "R9");
    idle(3, "R9");

    // R10: clear, then an error coinciding with clear wins
    drv(32'h0, 4'hF, 1, 1, 1, 0, 0, 0, 1, "R10");
    idle(1, "R10");
    drv(32'h8000_0000, 4'b0111, 0, 1, 1, 0, 0, 0, 0, "R10");
    drv(32'h0000_8888, 4'b0000, 1, 0, 0, 0, 1, 1, 0, "R10");
    drv(32'h0, 4'hF, 1, 1, 1, 0, 0, 0, 1, "R10");
    idle(3, "R10");
    drv(32'h0, 4'hF, 1, 1, 1, 0, 0, 0, 1, "R10");
    idle(1, "R10");

    // R12: varied received words with correct parity
    for (int k = 0; k < 12; k++) begin
      drv($urandom, 4'b0111, 0, 1, 1, 0, 0, 0, 0, "R12");
      drv($urandom, 4'($urandom), 0, 0, 0, 0, 1, 0, 0, "R12");
      drv($urandom, 4'($urandom), 1, 0, 0, 0, 1, 0, 0, "R12");
      idle(1, "R12");
    end
    idle(3, "R12");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule